// File: doc/BRIEF.md
# Byte-Mailbox Message Protocol Engine

This engine is the host side of a byte-wide mailbox shared with an embedded controller. It reports a single request as done or as an error. A transmit request sends a 4-byte header and then the payload, which arrives from a valid/ready byte stream. A receive request reads a 4-byte header, compares it with the expected values, and then either streams the payload out or empties the mailbox and reports an error.

The engine waits on the mailbox flag before each byte it moves. The write side waits on "full" and the read side waits on "empty". The wait re-checks the flag every `POLL_GAP + 1` cycles, for at most `POLL_LIMIT` checks. If the flag is still set after the last check, the request ends with a timeout error. Both limits are parameters given in clock cycles. A bench can therefore use short limits while silicon uses long ones.

The header layout is fixed:
- byte 0 is the opcode;
- byte 1 is the module ID;
- byte 2 is the high byte of the 16-bit payload length;
- byte 3 is the low byte of the payload length.

A message with zero length has no body and is only the header. When the engine drains a mismatched reply, the byte count comes from the reply's own length field, not from the expected length.

Top module: `mbox_msg_engine`

## Requirements
- R1: A send request (`req_read_i`=0) writes these bytes in this order:
  - the opcode;
  - the module ID;
  - `len[15:8]`;
  - `len[7:0]`;
  - then exactly `len` payload bytes, each taken on a `tx_valid_i && tx_ready_o` handshake and written in the order they were accepted.
- R2: A mailbox write (`mbox_wr_en_o`) happens only in a cycle where `mbox_full_i` is 0. While `mbox_full_i` stays 1, no write happens.
- R3: A mailbox read (`mbox_rd_en_o`) happens only in a cycle where `mbox_empty_i` is 0. Only bits [7:0] of `mbox_rd_data_i` are used.
- R4: A receive request (`req_read_i`=1) reads a 4-byte header and checks it against the expected values:
  - byte 0 against the opcode;
  - byte 1 against the module ID;
  - `{byte2,byte3}` against the length.
  On a match, the engine reads `len` payload bytes and presents each one on `rx_data_o` with a one-cycle `rx_valid_o` pulse. `done_o` pulses with the last byte.
- R5: On a header mismatch, the engine reads and discards exactly `{byte2,byte3}` further bytes and gives no `rx_valid_o`. It then pulses `err_o` with `err_code_o`=2'b01.
- R6: If a flag is still set after `POLL_LIMIT` checks, the request ends with `err_o` and `err_code_o`=2'b10. If the flag clears before the budget runs out, the transfer completes normally.
- R7: A request with zero length moves exactly the 4 header bytes and then pulses `done_o`.
- R8: A timeout during a drain stops the drain at once and reports code 2'b10, not 2'b01.
- R9: `busy_o` rises on the cycle after a request is accepted and falls in the cycle that `done_o` or `err_o` pulses. A `req_valid_i` while `busy_o` is 1 is ignored.
- R10: `done_o` and `err_o` never pulse together. `err_code_o` is 2'b00 except during an `err_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken when not busy |
| req_read_i | input | 1 | 0 = send message, 1 = receive and validate reply |
| req_module_i | input | 8 | Module ID to send or expect |
| req_opcode_i | input | 8 | Opcode to send or expect |
| req_len_i | input | 16 | Payload length to send or expect |
| tx_data_i | input | 8 | Payload byte to send |
| tx_valid_i | input | 1 | Payload byte valid |
| tx_ready_o | output | 1 | Engine takes a payload byte this cycle |
| rx_data_o | output | 8 | Received payload byte |
| rx_valid_o | output | 1 | Received payload byte strobe |
| mbox_full_i | input | 1 | Mailbox write side full |
| mbox_empty_i | input | 1 | Mailbox read side empty |
| mbox_wr_en_o | output | 1 | Mailbox byte write strobe |
| mbox_wr_data_o | output | 8 | Mailbox write byte |
| mbox_rd_en_o | output | 1 | Mailbox byte read strobe (pops) |
| mbox_rd_data_i | input | 32 | Mailbox read word, head byte in [7:0] |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle error pulse |
| err_code_o | output | 2 | 01 header mismatch, 10 timeout, valid with err_o |

## Verification
The assertions check these rules on every cycle:
- a mailbox strobe never coincides with its blocking flag;
- a drain never produces an `rx_valid_o` pulse;
- `busy_o` only rises after a request strobe;
- done and error stay exclusive, and the error code appears only with `err_o`.

Only the bench's scenarios can show the byte order of a header, the exact drain count taken from the reply's length field, and the success that follows a flag clearing part way through a wait. The same holds for a timeout overriding a mismatch in the middle of a drain, and for a request ignored while busy.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MSG_LEN_W = 16;
  localparam int unsigned HDR_BYTES = 4;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'b00,
    ERR_MISMATCH = 2'b01,
    ERR_TIMEOUT  = 2'b10
  } err_e;
endpackage

// File: rtl/mbox_byte_port.sv
module mbox_byte_port #(
  parameter int unsigned POLL_GAP   = 1000,
  parameter int unsigned POLL_LIMIT = 5000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        is_read_i,
  input  logic [7:0]  wdata_i,
  input  logic        full_i,
  input  logic        empty_i,
  input  logic [31:0] rd_data_i,
  output logic        wr_en_o,
  output logic [7:0]  wr_data_o,
  output logic        rd_en_o,
  output logic        ack_o,
  output logic [7:0]  rdata_o,
  output logic        tmo_o
);
  localparam int unsigned GAP_W = $clog2(POLL_GAP + 1);
  localparam int unsigned LIM_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [1:0] {P_IDLE, P_CHECK, P_WAIT} pst_e;

  pst_e             st_q;
  logic             rd_q;
  logic [7:0]       wd_q;
  logic [GAP_W-1:0] gap_q;
  logic [LIM_W-1:0] chk_q;
  logic             flag_set, last_chk, access;

  assign flag_set = rd_q ? empty_i : full_i;
  assign last_chk = (chk_q == LIM_W'(POLL_LIMIT - 1));
  assign access   = (st_q == P_CHECK) && !flag_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= P_IDLE;
      rd_q  <= 1'b0;
      wd_q  <= '0;
      gap_q <= '0;
      chk_q <= '0;
    end else begin
      case (st_q)
        P_IDLE: if (start_i) begin
          st_q  <= P_CHECK;
          rd_q  <= is_read_i;
          wd_q  <= wdata_i;
          chk_q <= '0;
        end
        P_CHECK: begin
          if (!flag_set || last_chk) st_q <= P_IDLE;
          else begin
            st_q  <= P_WAIT;
            gap_q <= '0;
          end
        end
        P_WAIT: begin
          if (gap_q == GAP_W'(POLL_GAP - 1)) begin
            st_q  <= P_CHECK;
            chk_q <= chk_q + 1'b1;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign wr_en_o   = access && !rd_q;
  assign rd_en_o   = access && rd_q;
  assign ack_o     = access;
  assign wr_data_o = wd_q;
  assign rdata_o   = rd_data_i[7:0];
  assign tmo_o     = (st_q == P_CHECK) && flag_set && last_chk;

  assert_ack_tmo_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && tmo_o));
endmodule

// File: rtl/mbox_tx_seq.sv
module mbox_tx_seq
  import mbox_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [7:0]           module_i,
  input  logic [7:0]           opcode_i,
  input  logic [MSG_LEN_W-1:0] len_i,
  input  logic [7:0]           tx_data_i,
  input  logic                 tx_valid_i,
  output logic                 tx_ready_o,
  output logic                 port_start_o,
  output logic [7:0]           port_wdata_o,
  input  logic                 port_ack_i,
  input  logic                 port_tmo_i,
  output logic                 active_o,
  output logic                 done_o,
  output logic                 err_o
);
  typedef enum logic [2:0] {T_IDLE, T_HDR, T_HDR_W, T_PAY, T_PAY_W} tst_e;

  tst_e                 st_q;
  logic [HDR_BYTES-1:0][7:0] hdr_q;
  logic [1:0]           idx_q;
  logic [MSG_LEN_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= T_IDLE;
      hdr_q  <= '0;
      idx_q  <= '0;
      rem_q  <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st_q)
        T_IDLE: if (start_i) begin
          hdr_q <= {len_i[7:0], len_i[15:8], module_i, opcode_i};
          rem_q <= len_i;
          idx_q <= '0;
          st_q  <= T_HDR;
        end
        T_HDR: st_q <= T_HDR_W;
        T_HDR_W: begin
          if (port_tmo_i) begin
            err_o <= 1'b1;
            st_q  <= T_IDLE;
          end else if (port_ack_i) begin
            if (idx_q == 2'd3) begin
              if (rem_q == '0) begin
                done_o <= 1'b1;
                st_q   <= T_IDLE;
              end else st_q <= T_PAY;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= T_HDR;
            end
          end
        end
        T_PAY: if (tx_valid_i) st_q <= T_PAY_W;
        T_PAY_W: begin
          if (port_tmo_i) begin
            err_o <= 1'b1;
            st_q  <= T_IDLE;
          end else if (port_ack_i) begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == MSG_LEN_W'(1)) begin
              done_o <= 1'b1;
              st_q   <= T_IDLE;
            end else st_q <= T_PAY;
          end
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign tx_ready_o   = (st_q == T_PAY);
  assign port_start_o = (st_q == T_HDR) || ((st_q == T_PAY) && tx_valid_i);
  assign port_wdata_o = (st_q == T_PAY) ? tx_data_i : hdr_q[idx_q];
  assign active_o     = (st_q != T_IDLE);

  assert_no_start_while_waiting_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_start_o |=> !port_start_o);
endmodule

// File: rtl/mbox_rx_seq.sv
module mbox_rx_seq
  import mbox_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [7:0]           module_i,
  input  logic [7:0]           opcode_i,
  input  logic [MSG_LEN_W-1:0] len_i,
  output logic                 port_start_o,
  input  logic                 port_ack_i,
  input  logic [7:0]           port_rdata_i,
  input  logic                 port_tmo_i,
  output logic [7:0]           rx_data_o,
  output logic                 rx_valid_o,
  output logic                 active_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic [1:0]           err_code_o
);
  typedef enum logic [2:0] {R_IDLE, R_HDR, R_HDR_W, R_CMP, R_BODY, R_BODY_W} rst_e;

  rst_e                      st_q;
  logic [HDR_BYTES-1:0][7:0] hdr_q;
  logic [1:0]                idx_q;
  logic [7:0]                mod_q, op_q;
  logic [MSG_LEN_W-1:0]      len_q, rem_q, rlen;
  logic                      drain_q, match;

  assign rlen  = {hdr_q[2], hdr_q[3]};
  assign match = (hdr_q[0] == op_q) && (hdr_q[1] == mod_q) && (rlen == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= R_IDLE;
      hdr_q      <= '0;
      idx_q      <= '0;
      mod_q      <= '0;
      op_q       <= '0;
      len_q      <= '0;
      rem_q      <= '0;
      drain_q    <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
    end else begin
      rx_valid_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
      case (st_q)
        R_IDLE: if (start_i) begin
          mod_q <= module_i;
          op_q  <= opcode_i;
          len_q <= len_i;
          idx_q <= '0;
          st_q  <= R_HDR;
        end
        R_HDR: st_q <= R_HDR_W;
        R_HDR_W: begin
          if (port_tmo_i) begin
            err_o      <= 1'b1;
            err_code_o <= ERR_TIMEOUT;
            st_q       <= R_IDLE;
          end else if (port_ack_i) begin
            hdr_q[idx_q] <= port_rdata_i;
            idx_q        <= idx_q + 1'b1;
            st_q         <= (idx_q == 2'd3) ? R_CMP : R_HDR;
          end
        end
        R_CMP: begin
          if (match) begin
            if (len_q == '0) begin
              done_o <= 1'b1;
              st_q   <= R_IDLE;
            end else begin
              rem_q   <= len_q;
              drain_q <= 1'b0;
              st_q    <= R_BODY;
            end
          end else if (rlen == '0) begin
            err_o      <= 1'b1;
            err_code_o <= ERR_MISMATCH;
            st_q       <= R_IDLE;
          end else begin
            rem_q   <= rlen;
            drain_q <= 1'b1;
            st_q    <= R_BODY;
          end
        end
        R_BODY: st_q <= R_BODY_W;
        R_BODY_W: begin
          if (port_tmo_i) begin
            err_o      <= 1'b1;
            err_code_o <= ERR_TIMEOUT;
            st_q       <= R_IDLE;
          end else if (port_ack_i) begin
            if (!drain_q) begin
              rx_valid_o <= 1'b1;
              rx_data_o  <= port_rdata_i;
            end
            rem_q <= rem_q - 1'b1;
            if (rem_q == MSG_LEN_W'(1)) begin
              st_q <= R_IDLE;
              if (drain_q) begin
                err_o      <= 1'b1;
                err_code_o <= ERR_MISMATCH;
              end else done_o <= 1'b1;
            end else st_q <= R_BODY;
          end
        end
        default: st_q <= R_IDLE;
      endcase
    end
  end

  assign port_start_o = (st_q == R_HDR) || (st_q == R_BODY);
  assign active_o     = (st_q != R_IDLE);

  assert_drain_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == R_BODY_W && drain_q) |=> !rx_valid_o);
endmodule

// File: rtl/mbox_msg_engine.sv
module mbox_msg_engine
  import mbox_pkg::*;
#(
  parameter int unsigned POLL_GAP   = 1000,
  parameter int unsigned POLL_LIMIT = 5000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_read_i,
  input  logic [7:0]  req_module_i,
  input  logic [7:0]  req_opcode_i,
  input  logic [15:0] req_len_i,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_valid_i,
  output logic        tx_ready_o,
  output logic [7:0]  rx_data_o,
  output logic        rx_valid_o,
  input  logic        mbox_full_i,
  input  logic        mbox_empty_i,
  output logic        mbox_wr_en_o,
  output logic [7:0]  mbox_wr_data_o,
  output logic        mbox_rd_en_o,
  input  logic [31:0] mbox_rd_data_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [1:0]  err_code_o
);
  logic       accept;
  logic       tx_active, tx_done, tx_err, tx_pstart;
  logic [7:0] tx_pwdata;
  logic       rx_active, rx_done, rx_err, rx_pstart;
  logic [1:0] rx_code;
  logic       p_ack, p_tmo;
  logic [7:0] p_rdata;

  assign busy_o = tx_active || rx_active;
  assign accept = req_valid_i && !busy_o;

  mbox_byte_port #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_port (
    .clk_i, .rst_ni,
    .start_i   (tx_pstart || rx_pstart),
    .is_read_i (rx_pstart),
    .wdata_i   (tx_pwdata),
    .full_i    (mbox_full_i),
    .empty_i   (mbox_empty_i),
    .rd_data_i (mbox_rd_data_i),
    .wr_en_o   (mbox_wr_en_o),
    .wr_data_o (mbox_wr_data_o),
    .rd_en_o   (mbox_rd_en_o),
    .ack_o     (p_ack),
    .rdata_o   (p_rdata),
    .tmo_o     (p_tmo)
  );

  mbox_tx_seq u_tx (
    .clk_i, .rst_ni,
    .start_i      (accept && !req_read_i),
    .module_i     (req_module_i),
    .opcode_i     (req_opcode_i),
    .len_i        (req_len_i),
    .tx_data_i, .tx_valid_i, .tx_ready_o,
    .port_start_o (tx_pstart),
    .port_wdata_o (tx_pwdata),
    .port_ack_i   (p_ack && tx_active),
    .port_tmo_i   (p_tmo && tx_active),
    .active_o     (tx_active),
    .done_o       (tx_done),
    .err_o        (tx_err)
  );

  mbox_rx_seq u_rx (
    .clk_i, .rst_ni,
    .start_i      (accept && req_read_i),
    .module_i     (req_module_i),
    .opcode_i     (req_opcode_i),
    .len_i        (req_len_i),
    .port_start_o (rx_pstart),
    .port_ack_i   (p_ack && rx_active),
    .port_rdata_i (p_rdata),
    .port_tmo_i   (p_tmo && rx_active),
    .rx_data_o, .rx_valid_o,
    .active_o     (rx_active),
    .done_o       (rx_done),
    .err_o        (rx_err),
    .err_code_o   (rx_code)
  );

  assign done_o     = tx_done || rx_done;
  assign err_o      = tx_err || rx_err;
  assign err_code_o = tx_err ? ERR_TIMEOUT : rx_code;

  assert_wr_needs_space_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbox_wr_en_o |-> !mbox_full_i);
  assert_rd_needs_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbox_rd_en_o |-> !mbox_empty_i);
  assert_busy_from_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));
  assert_done_err_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  assert_code_with_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o != 2'b00) == err_o);
endmodule

// File: tb/mbox_msg_engine_bench.sv
module mbox_msg_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 3;
  localparam int LIMIT = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_read = 0;
  logic [7:0] req_mod = 0, req_op = 0;
  logic [15:0] req_len = 0;
  logic [7:0] tx_data = 0;
  logic tx_valid = 0, tx_ready;
  logic [7:0] rx_data;
  logic rx_valid;
  logic full_force = 0, empty_force = 0;
  logic wr_en, rd_en;
  logic [7:0] wr_data;
  logic [31:0] rd_data;
  logic busy, done, err;
  logic [1:0] err_code;

  byte unsigned wr_log[$], rd_q[$], rx_log[$], pay[$];
  int hs_cnt = 0, rd_cnt = 0, checks = 0, fails = 0, cyc = 0;
  logic [7:0] rd_head = 0;
  logic got_done, got_err, busy_seen_low;
  logic [1:0] got_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_data = (rd_cnt > 0) ? {24'hA5C3E1, rd_head} : 32'hFFFF_FF00;

  mbox_msg_engine #(.POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) u_mbox_msg_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_read_i(req_read), .req_module_i(req_mod),
    .req_opcode_i(req_op), .req_len_i(req_len),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .mbox_full_i(full_force), .mbox_empty_i(empty_force || rd_cnt == 0),
    .mbox_wr_en_o(wr_en), .mbox_wr_data_o(wr_data),
    .mbox_rd_en_o(rd_en), .mbox_rd_data_i(rd_data),
    .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(err_code)
  );

  task automatic refresh();
    rd_cnt  = rd_q.size();
    rd_head = (rd_q.size() > 0) ? rd_q[0] : 8'h00;
  endtask

  // mailbox model: capture strobes before the edge updates state, apply after
  always @(posedge clk) begin
    logic w, r, rv, hs;
    logic [7:0] d, rxd;
    w = wr_en; r = rd_en; d = wr_data; rv = rx_valid; rxd = rx_data;
    hs = tx_valid && tx_ready;
    cyc++;
    #1;
    if (w) wr_log.push_back(d);
    if (r && rd_q.size() > 0) void'(rd_q.pop_front());
    if (rv) rx_log.push_back(rxd);
    if (hs) hs_cnt++;
    refresh();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic request(input bit rd, input byte unsigned m, input byte unsigned o,
                         input int unsigned n);
    @(negedge clk);
    req_read = rd; req_mod = m; req_op = o; req_len = 16'(n);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_end(input int max_cyc);
    got_done = 0; got_err = 0; got_code = 0; busy_seen_low = 0;
    for (int i = 0; i < max_cyc; i++) begin
      tx_valid = (hs_cnt < pay.size());
      tx_data  = (hs_cnt < pay.size()) ? pay[hs_cnt] : 8'h00;
      if (done || err) begin
        got_done = done; got_err = err; got_code = err_code;
        break;
      end
      if (!busy) busy_seen_low = 1;
      @(negedge clk);
    end
    tx_valid = 0;
    @(negedge clk);
  endtask

  task automatic clear_logs();
    wr_log.delete(); rx_log.delete(); pay.delete(); hs_cnt = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !err && !wr_en && !rd_en && !tx_ready && err_code == 0,
        "R9 reset idle", {busy, done, err, wr_en, rd_en, tx_ready}, 0);
  endtask

  task automatic t_send3();
    byte unsigned exp[$] = '{8'h21, 8'h07, 8'h00, 8'h03, 8'h11, 8'h22, 8'h33};
    clear_logs();
    pay = '{8'h11, 8'h22, 8'h33};
    request(0, 8'h07, 8'h21, 3);
    chk(busy, "R9 busy after accept", busy, 1);
    wait_end(300);
    chk(got_done && !got_err && got_code == 0, "R10 send done clean", {got_done, got_err, got_code}, 4);
    chk(!busy_seen_low, "R9 busy held until done", busy_seen_low, 0);
    chk(!busy, "R9 busy low after done", busy, 0);
    chk(wr_log.size() == 7, "R1 send byte count", wr_log.size(), 7);
    for (int i = 0; i < 7 && i < wr_log.size(); i++)
      chk(wr_log[i] == exp[i], "R1 send byte order", wr_log[i], exp[i]);
  endtask

  task automatic t_send_full_stall();
    clear_logs();
    pay = '{8'h5A};
    full_force = 1;
    request(0, 8'h02, 8'h40, 1);
    repeat (10) @(negedge clk);
    chk(wr_log.size() == 0, "R2 no write while full", wr_log.size(), 0);
    chk(busy && !err, "R6 still waiting within budget", {busy, err}, 2);
    full_force = 0;
    wait_end(300);
    chk(got_done, "R6 success after flag clears", got_done, 1);
    chk(wr_log.size() == 5 && wr_log[4] == 8'h5A, "R2 write completes after full",
        wr_log.size(), 5);
  endtask

  task automatic t_send_zero();
    clear_logs();
    request(0, 8'h03, 8'h0E, 0);
    wait_end(300);
    chk(got_done && wr_log.size() == 4, "R7 zero length send", wr_log.size(), 4);
    chk(wr_log.size() == 4 && wr_log[2] == 0 && wr_log[3] == 0, "R7 zero length field",
        wr_log.size() == 4 ? {wr_log[2], wr_log[3]} : 16'hFFFF, 0);
  endtask

  task automatic t_recv_match();
    clear_logs();
    rd_q = '{8'h10, 8'h01, 8'h00, 8'h02, 8'hC4, 8'h9B};
    refresh();
    empty_force = 1;
    request(1, 8'h01, 8'h10, 2);
    repeat (8) @(negedge clk);
    chk(rd_q.size() == 6, "R3 no read while empty", rd_q.size(), 6);
    empty_force = 0;
    wait_end(300);
    chk(got_done && !got_err, "R4 match done", {got_done, got_err}, 2);
    chk(rx_log.size() == 2, "R4 payload count", rx_log.size(), 2);
    chk(rx_log.size() == 2 && rx_log[0] == 8'hC4 && rx_log[1] == 8'h9B,
        "R3 low byte payload", rx_log.size() > 0 ? rx_log[0] : 0, 8'hC4);
    chk(rd_q.size() == 0, "R4 mailbox consumed", rd_q.size(), 0);
  endtask

  task automatic t_recv_zero();
    clear_logs();
    rd_q = '{8'h30, 8'h05, 8'h00, 8'h00, 8'hEE};
    refresh();
    request(1, 8'h05, 8'h30, 0);
    wait_end(300);
    chk(got_done && rx_log.size() == 0 && rd_q.size() == 1, "R7 zero length receive",
        rd_q.size(), 1);
    rd_q.delete(); refresh();
  endtask

  task automatic t_recv_mismatch();
    clear_logs();
    rd_q = '{8'h99, 8'h01, 8'h00, 8'h03, 8'hA1, 8'hA2, 8'hA3, 8'h77};
    refresh();
    request(1, 8'h01, 8'h10, 3);
    wait_end(400);
    chk(got_err && got_code == 2'b01, "R5 mismatch code", got_code, 1);
    chk(rx_log.size() == 0, "R5 drain silent", rx_log.size(), 0);
    chk(rd_q.size() == 1 && rd_q[0] == 8'h77, "R5 drain exact length", rd_q.size(), 1);
    // length mismatch with announced length zero: nothing drained
    clear_logs();
    rd_q = '{8'h10, 8'h01, 8'h00, 8'h00, 8'h66};
    refresh();
    request(1, 8'h01, 8'h10, 4);
    wait_end(300);
    chk(got_err && got_code == 2'b01 && rd_q.size() == 1, "R5 zero length mismatch",
        rd_q.size(), 1);
    rd_q.delete(); refresh();
  endtask

  task automatic t_send_timeout();
    clear_logs();
    pay = '{8'h01};
    full_force = 1;
    request(0, 8'h01, 8'h02, 1);
    wait_end(400);
    chk(got_err && got_code == 2'b10, "R6 timeout code", got_code, 2);
    chk(wr_log.size() == 0, "R2 no write on timeout", wr_log.size(), 0);
    chk(!busy, "R9 idle after timeout", busy, 0);
    full_force = 0;
  endtask

  task automatic t_drain_timeout();
    clear_logs();
    rd_q = '{8'h44, 8'h01, 8'h00, 8'h05, 8'hB1, 8'hB2};
    refresh();
    request(1, 8'h01, 8'h10, 5);
    wait_end(500);
    chk(got_err && got_code == 2'b10, "R8 drain timeout priority", got_code, 2);
    chk(rd_q.size() == 0 && rx_log.size() == 0, "R8 drain stopped", rx_log.size(), 0);
  endtask

  task automatic t_ignore_busy();
    int dones = 0;
    clear_logs();
    rd_q = '{8'h10, 8'h01, 8'h00, 8'h00};
    refresh();
    pay = '{8'hD0};
    full_force = 1;
    request(0, 8'h08, 8'h50, 1);
    request(1, 8'h01, 8'h10, 0);
    repeat (4) @(negedge clk);
    chk(rd_q.size() == 4, "R9 request ignored while busy", rd_q.size(), 4);
    full_force = 0;
    wait_end(300);
    if (got_done) dones++;
    repeat (30) begin
      @(negedge clk);
      if (done || busy) dones++;
    end
    chk(dones == 1 && wr_log.size() == 5, "R9 only first request ran", dones, 1);
    chk(rd_q.size() == 4, "R9 ignored receive left mailbox", rd_q.size(), 4);
    rd_q.delete(); refresh();
  endtask

  initial begin
    refresh();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_send3();
    t_send_full_stall();
    t_send_zero();
    t_recv_match();
    t_recv_zero();
    t_recv_mismatch();
    t_send_timeout();
    t_drain_timeout();
    t_ignore_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule